// File: doc/BRIEF.md
# Descriptor-Ring Receive DMA Channel

This block moves an incoming framed word stream into system memory. Software builds a ring of two-word descriptors in a 4096-byte aligned page, each naming a buffer and its size. It then posts work by advancing a pointer register. For each frame the engine reserves a programmable number of bytes at the start of the first buffer, then a 4-byte status word. The payload follows, and when a buffer fills the engine continues in the buffer of the next descriptor. When the frame ends, the engine writes the status word with the frame length and a count of the descriptors it used, and raises a one-cycle interrupt.

When no posted descriptor is left and data is waiting, a policy bit chooses between two actions. The engine can drop the rest of the frame and carry on, or it can halt and report an overflow. Bus errors on descriptor reads or buffer writes, and descriptors too small to be used, also halt the channel with an error code. The code stays visible until software clears the enable bit.

Top module: `rx_desc_dma`

## Requirements
- R1: After reset the status register reads 0, `irq`, `mem_req` and `st_ready` are low, and the channel stays disabled.
- R2: Register 0 holds enable in bit 0, the frame offset in bits [7:1] and overflow-continue in bit 10, and its other bits read 0. Register 1 holds the ring base, with bits [11:0] reading 0. Register 2 holds the posted byte offset, with bits [2:0] and [31:12] reading 0. Register 3 reads current descriptor byte offset in [11:0], state in [15:12] and error in [19:16]. Read data appears one clock after the address.
- R3: A descriptor at byte offset c is read as two words: the control word at base+c and the buffer address at base+c+4. The byte count is in control bits [12:0] and end-of-table is in bit 28. After the address word is read, c advances by 8, or returns to 0 if end-of-table was set. Read requests hold their address until acknowledged.
- R4: In the first buffer of a frame, the bytes before the offset are left untouched. The offset is used with bits [1:0] cleared. The status word goes at buffer+offset, and payload words follow from buffer+offset+4 in arrival order.
- R5: When the current buffer's room is used up, the frame continues at the start of the next posted descriptor's buffer. Byte counts are used with bits [1:0] cleared.
- R6: The status word holds the payload length in bytes in [15:0] and the number of descriptors used minus one in [19:16]. Bits [31:20] are 0. It is written after the last payload word.
- R7: `irq` is a single-cycle pulse, raised once per frame after the status word write is acknowledged.
- R8: The state field reads 0 when disabled, 1 when active, 2 when idle-waiting (the current offset equals the posted offset with no frame in progress) and 3 when halted. The error field is non-zero only while halted.
- R9: With overflow-continue set, a frame that finds no posted descriptor is consumed and discarded. Nothing is written, no interrupt is raised, and the channel remains active.
- R10: With overflow-continue clear, the same case halts the channel with error 2. While halted, `st_ready` and `mem_req` stay low.
- R11: An error response on a descriptor read halts the channel with error 4. An error response on a payload or status write halts it with error 3.
- R12: A first descriptor whose count is below offset+4, or a later descriptor with count 0, halts the channel with error 1.
- R13: Clearing enable takes effect only between frames or while halted, and it clears the error. Setting enable from the disabled state restarts at descriptor offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| st_valid | input | 1 | Stream word valid |
| st_data | input | 32 | Stream word |
| st_last | input | 1 | Last word of frame |
| st_ready | output | 1 | Stream word accepted when high with valid |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a word write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access completed with an error |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| irq | output | 1 | Frame completion pulse |

## Verification
Random frames of mixed length and offset wander around a four-entry ring that ends with the end-of-table bit. A design that mishandled the wrap, the room left after the offset, or the move into the next buffer would place payload or status words at the wrong addresses. A wrong descriptor count or length would show up in the status word. The bench also aims directed cases at the empty-ring policy both ways. A design that stalled or halted under overflow-continue would hang the frame or report a wrong state, and one that wrote something anyway would leave a status word in memory. Other directed cases inject bus errors on a descriptor read and on a payload write, and give a descriptor too small for the offset. A design that reported the wrong code, advanced the descriptor pointer at the wrong moment, or kept accepting data while halted would read back a wrong status word. Re-enabling after a halt must show offset 0 and no error.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  typedef enum logic [3:0] {
    ST_OFF  = 4'd0,
    ST_RUN  = 4'd1,
    ST_WAIT = 4'd2,
    ST_HALT = 4'd3
  } chan_state_e;

  typedef enum logic [3:0] {
    ER_NONE  = 4'd0,
    ER_PROTO = 4'd1,
    ER_OVFL  = 4'd2,
    ER_BUFWR = 4'd3,
    ER_DESC  = 4'd4
  } chan_err_e;

  // Status word written in front of each frame's payload.
  typedef struct packed {
    logic [11:0] rsvd;
    logic [3:0]  ndesc_m1;
    logic [15:0] len;
  } rx_hdr_t;

  localparam int EOT_BIT = 28;

endpackage

// File: rtl/rxd_regs.sv
module rxd_regs #(
  parameter int RING_BITS = 12,
  parameter int OFF_BITS  = 7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      reg_we,
  input  logic [1:0]                reg_addr,
  input  logic [31:0]               reg_wdata,
  input  logic [31:0]               status_word,
  output logic                      en,
  output logic [OFF_BITS-1:0]       offset,
  output logic                      ovf_cont,
  output logic [31-RING_BITS:0]     ring_base,
  output logic [RING_BITS-4:0]      posted,
  output logic [31:0]               reg_rdata
);
  localparam int BASE_W = 32 - RING_BITS;
  localparam int IDX_W  = RING_BITS - 3;
  localparam int CPAD_W = 32 - 4 - OFF_BITS;

  logic [31:0] rd_mux;

  always_comb begin
    unique case (reg_addr)
      2'd0:    rd_mux = {{CPAD_W{1'b0}}, ovf_cont, 2'b00, offset, en};
      2'd1:    rd_mux = {ring_base, {RING_BITS{1'b0}}};
      2'd2:    rd_mux = {{BASE_W{1'b0}}, posted, 3'b000};
      default: rd_mux = status_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en        <= 1'b0;
      offset    <= '0;
      ovf_cont  <= 1'b0;
      ring_base <= '0;
      posted    <= '0;
      reg_rdata <= '0;
    end else begin
      reg_rdata <= rd_mux;
      if (reg_we) begin
        unique case (reg_addr)
          2'd0: begin
            en       <= reg_wdata[0];
            offset   <= reg_wdata[OFF_BITS:1];
            ovf_cont <= reg_wdata[10];
          end
          2'd1:    ring_base <= reg_wdata[31:RING_BITS];
          2'd2:    posted    <= reg_wdata[IDX_W+2:3];
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/rxd_engine.sv
module rxd_engine
  import rxd_pkg::*;
#(
  parameter int RING_BITS = 12,
  parameter int BC_BITS   = 13,
  parameter int OFF_BITS  = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic [OFF_BITS-1:0]   offset,
  input  logic                  ovf_cont,
  input  logic [31-RING_BITS:0] ring_base,
  input  logic [RING_BITS-4:0]  posted,
  input  logic                  st_valid,
  input  logic [31:0]           st_data,
  input  logic                  st_last,
  output logic                  st_ready,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [31:0]           mem_addr,
  output logic [31:0]           mem_wdata,
  input  logic                  mem_ack,
  input  logic                  mem_err,
  input  logic [31:0]           mem_rdata,
  output logic                  irq,
  output logic [3:0]            state_code,
  output logic [3:0]            err_code,
  output logic [RING_BITS-4:0]  cur_idx
);
  localparam int IDX_W  = RING_BITS - 3;
  localparam int ROOM_W = BC_BITS + 1;

  typedef enum logic [3:0] {
    E_OFF, E_READY, E_DCTL, E_DADR, E_RECV, E_WRITE, E_HDR, E_DROP, E_HALT
  } eng_e;

  eng_e                fsm;
  logic [IDX_W-1:0]    cur;
  chan_err_e           err;
  logic [BC_BITS-1:0]  bc_q;
  logic                eot_q;
  logic                first_q;
  logic [ROOM_W-1:0]   room;
  logic [ROOM_W-1:0]   off_q;
  logic [31:0]         wptr;
  logic [31:0]         hdr_ptr;
  logic [31:0]         wbuf;
  logic [15:0]         len;
  logic [3:0]          nd;
  logic                last_q;
  logic                irq_q;

  logic                avail;
  logic [ROOM_W-1:0]   bc_w;
  logic [ROOM_W-1:0]   off_w;
  logic [ROOM_W-1:0]   need_first;
  logic [31:0]         buf_base;
  rx_hdr_t             hdr_word;
  wire                 unused_off = ^offset[1:0];

  assign avail      = (cur != posted);
  assign bc_w       = {1'b0, bc_q[BC_BITS-1:2], 2'b00};
  assign off_w      = ROOM_W'({offset[OFF_BITS-1:2], 2'b00});
  assign need_first = off_q + ROOM_W'(4);
  assign buf_base   = {mem_rdata[31:2], 2'b00};
  assign hdr_word   = '{rsvd: '0, ndesc_m1: nd, len: len};

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm     <= E_OFF;
      cur     <= '0;
      err     <= ER_NONE;
      bc_q    <= '0;
      eot_q   <= 1'b0;
      first_q <= 1'b0;
      room    <= '0;
      off_q   <= '0;
      wptr    <= '0;
      hdr_ptr <= '0;
      wbuf    <= '0;
      len     <= '0;
      nd      <= '0;
      last_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (fsm)
        E_OFF: begin
          if (en) begin
            cur <= '0;
            fsm <= E_READY;
          end
        end
        E_READY: begin
          if (!en) begin
            fsm <= E_OFF;
          end else if (st_valid) begin
            if (avail) begin
              fsm     <= E_DCTL;
              first_q <= 1'b1;
              len     <= '0;
              nd      <= '0;
              off_q   <= off_w;
            end else if (ovf_cont) begin
              fsm <= E_DROP;
            end else begin
              fsm <= E_HALT;
              err <= ER_OVFL;
            end
          end
        end
        E_DCTL: begin
          if (mem_ack) begin
            if (mem_err) begin
              fsm <= E_HALT;
              err <= ER_DESC;
            end else begin
              bc_q  <= mem_rdata[BC_BITS-1:0];
              eot_q <= mem_rdata[EOT_BIT];
              fsm   <= E_DADR;
            end
          end
        end
        E_DADR: begin
          if (mem_ack) begin
            if (mem_err) begin
              fsm <= E_HALT;
              err <= ER_DESC;
            end else begin
              cur     <= eot_q ? '0 : cur + 1'b1;
              first_q <= 1'b0;
              if (first_q) begin
                if (bc_w < need_first) begin
                  fsm <= E_HALT;
                  err <= ER_PROTO;
                end else begin
                  hdr_ptr <= buf_base + 32'(off_q);
                  wptr    <= buf_base + 32'(off_q) + 32'd4;
                  room    <= bc_w - need_first;
                  fsm     <= E_RECV;
                end
              end else if (bc_w == '0) begin
                fsm <= E_HALT;
                err <= ER_PROTO;
              end else begin
                wptr <= buf_base;
                room <= bc_w;
                nd   <= (nd == 4'hF) ? nd : nd + 4'd1;
                fsm  <= E_RECV;
              end
            end
          end
        end
        E_RECV: begin
          if (room == '0) begin
            if (avail) begin
              fsm <= E_DCTL;
            end else if (ovf_cont) begin
              fsm <= E_DROP;
            end else begin
              fsm <= E_HALT;
              err <= ER_OVFL;
            end
          end else if (st_valid) begin
            wbuf   <= st_data;
            last_q <= st_last;
            fsm    <= E_WRITE;
          end
        end
        E_WRITE: begin
          if (mem_ack) begin
            if (mem_err) begin
              fsm <= E_HALT;
              err <= ER_BUFWR;
            end else begin
              wptr <= wptr + 32'd4;
              room <= room - ROOM_W'(4);
              len  <= len + 16'd4;
              fsm  <= last_q ? E_HDR : E_RECV;
            end
          end
        end
        E_HDR: begin
          if (mem_ack) begin
            if (mem_err) begin
              fsm <= E_HALT;
              err <= ER_BUFWR;
            end else begin
              irq_q <= 1'b1;
              fsm   <= E_READY;
            end
          end
        end
        E_DROP: begin
          if (st_valid && st_last) fsm <= E_READY;
        end
        E_HALT: begin
          if (!en) begin
            fsm <= E_OFF;
            err <= ER_NONE;
          end
        end
        default: fsm <= E_OFF;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (fsm)
      E_DCTL: begin
        mem_req  = 1'b1;
        mem_addr = {ring_base, cur, 3'b000};
      end
      E_DADR: begin
        mem_req  = 1'b1;
        mem_addr = {ring_base, cur, 3'b100};
      end
      E_WRITE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = wptr;
        mem_wdata = wbuf;
      end
      E_HDR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = hdr_ptr;
        mem_wdata = hdr_word;
      end
      default: ;
    endcase
  end

  always_comb begin
    unique case (fsm)
      E_OFF:   state_code = ST_OFF;
      E_HALT:  state_code = ST_HALT;
      E_READY: state_code = avail ? ST_RUN : ST_WAIT;
      default: state_code = ST_RUN;
    endcase
  end

  assign st_ready = ((fsm == E_RECV) && (room != '0)) || (fsm == E_DROP);
  assign irq      = irq_q;
  assign err_code = err;
  assign cur_idx  = cur;

endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma #(
  parameter int RING_BITS = 12,
  parameter int BC_BITS   = 13,
  parameter int OFF_BITS  = 7
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        st_valid,
  input  logic [31:0] st_data,
  input  logic        st_last,
  output logic        st_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic        mem_err,
  input  logic [31:0] mem_rdata,
  output logic        irq
);
  localparam int IDX_W  = RING_BITS - 3;
  localparam int SPAD_W = 32 - RING_BITS - 8;

  logic                  w_en;
  logic [OFF_BITS-1:0]   w_off;
  logic                  w_oc;
  logic [31-RING_BITS:0] w_base;
  logic [IDX_W-1:0]      w_posted;
  logic [IDX_W-1:0]      w_cur;
  logic [3:0]            w_state;
  logic [3:0]            w_err;
  logic [31:0]           w_status;

  assign w_status = {{SPAD_W{1'b0}}, w_err, w_state, w_cur, 3'b000};

  rxd_regs #(.RING_BITS(RING_BITS), .OFF_BITS(OFF_BITS)) u_regs (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .status_word(w_status),
    .en(w_en), .offset(w_off), .ovf_cont(w_oc),
    .ring_base(w_base), .posted(w_posted),
    .reg_rdata(reg_rdata)
  );

  rxd_engine #(.RING_BITS(RING_BITS), .BC_BITS(BC_BITS), .OFF_BITS(OFF_BITS)) u_eng (
    .clk(clk), .rst(rst),
    .en(w_en), .offset(w_off), .ovf_cont(w_oc),
    .ring_base(w_base), .posted(w_posted),
    .st_valid(st_valid), .st_data(st_data), .st_last(st_last), .st_ready(st_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .irq(irq), .state_code(w_state), .err_code(w_err), .cur_idx(w_cur)
  );

endmodule

// File: rtl/rxd_chk.sv
module rxd_chk #(
  parameter int RING_BITS = 12
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  mem_req,
  input logic                  mem_ack,
  input logic                  mem_we,
  input logic [31:0]           mem_addr,
  input logic                  irq,
  input logic                  st_ready,
  input logic [3:0]            state_code,
  input logic [3:0]            err_code,
  input logic [31-RING_BITS:0] ring_base
);

  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R3
  ring_read_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> (mem_addr[31:RING_BITS] == ring_base));

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code == 4'd3) |-> (!st_ready && !mem_req));

  // R8
  err_only_halted_chk: assert property (@(posedge clk) disable iff (rst)
    (err_code != 4'd0) |-> (state_code == 4'd3));

endmodule

bind rx_desc_dma rxd_chk #(.RING_BITS(RING_BITS)) u_chk (
  .clk(clk), .rst(rst),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we), .mem_addr(mem_addr),
  .irq(irq), .st_ready(st_ready),
  .state_code(w_state), .err_code(w_err), .ring_base(w_base)
);

// File: tb/rx_desc_dma_tb.sv
module rx_desc_dma_tb;
  localparam logic [31:0] BASE = 32'h0001_0000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        st_valid;
  logic [31:0] st_data;
  logic        st_last;
  logic        st_ready;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        irq;

  rx_desc_dma u_dut (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .st_valid(st_valid), .st_data(st_data), .st_last(st_last), .st_ready(st_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .irq(irq)
  );

  int checks = 0;
  int fails  = 0;
  int irq_cnt = 0;
  bit finished = 0;
  logic [31:0] mem [int unsigned];
  bit          err_on = 0;
  logic [31:0] err_addr = '0;

  function automatic logic [31:0] bufa(input int i);
    return 32'h0002_0000 + 32'(i) * 32'h400;
  endfunction

  function automatic logic [31:0] rdm(input logic [31:0] a);
    if (mem.exists(a >> 2)) return mem[a >> 2];
    return 32'hDEAD_BEEF;
  endfunction

  function automatic logic [31:0] hdr(input int nbytes, input int ndesc);
    return {12'h000, 4'(ndesc - 1), 16'(nbytes)};
  endfunction

  // memory responder: one-cycle acknowledge after a request is seen
  initial begin
    mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        mem_ack = 1'b1;
        mem_err = err_on && (mem_addr == err_addr);
        if (mem_we) begin
          if (!mem_err) mem[mem_addr >> 2] = mem_wdata;
        end else begin
          mem_rdata = rdm(mem_addr);
        end
      end else begin
        mem_ack = 1'b0;
        mem_err = 1'b0;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (irq) irq_cnt++;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic set_desc(input int idx, input int bc, input bit eot, input logic [31:0] a);
    mem[(BASE + 32'(idx) * 8) >> 2]     = (32'(eot) << 28) | 32'(bc);
    mem[(BASE + 32'(idx) * 8 + 4) >> 2] = a;
  endtask

  task automatic send_frame(input int n, input logic [31:0] tagv);
    for (int i = 0; i < n; i++) begin
      st_valid = 1'b1;
      st_data  = tagv + 32'(i);
      st_last  = (i == n - 1);
      while (!st_ready) @(negedge clk);
      @(negedge clk);
    end
    st_valid = 1'b0;
    st_last  = 1'b0;
  endtask

  task automatic wait_irq(input int prev);
    for (int k = 0; k < 2000 && irq_cnt == prev; k++) @(negedge clk);
  endtask

  task automatic hold_valid(input int cycles);
    st_valid = 1'b1; st_data = 32'h5555_0000; st_last = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int prev;
    int unsigned seed;
    rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    st_valid = 1'b0; st_data = '0; st_last = 1'b0;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 st_ready", {31'b0, st_ready}, 32'd0);
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
    rd_reg(2'd3, rd); chk("R1 status", rd, 32'h0);

    // R2 register layout
    wr_reg(2'd0, 32'hFFFF_FFFE); rd_reg(2'd0, rd); chk("R2 control", rd, 32'h0000_04FE);
    wr_reg(2'd1, BASE | 32'h0ABC); rd_reg(2'd1, rd); chk("R2 base", rd, BASE);
    wr_reg(2'd2, 32'hFFFF_FFFF); rd_reg(2'd2, rd); chk("R2 posted", rd, 32'h0000_0FF8);
    wr_reg(2'd2, 32'h0);

    // R8 idle wait after enable, offset 8
    wr_reg(2'd0, 32'h11);
    rd_reg(2'd3, rd); chk("R8 idle wait", rd, 32'h2000);

    set_desc(0, 64, 0, bufa(0));
    set_desc(1, 16, 0, bufa(1));
    set_desc(2, 64, 0, bufa(2));
    mem[(bufa(0) + 4) >> 2] = 32'h1234_5678;

    // R4/R6 single-buffer frame
    prev = irq_cnt;
    wr_reg(2'd2, 32'd8);
    send_frame(5, 32'hA000_0000);
    wait_irq(prev);
    chk("R7 irq A", 32'(irq_cnt), 32'(prev + 1));
    chk("R6 header A", rdm(bufa(0) + 8), hdr(20, 1));
    chk("R4 offset untouched", rdm(bufa(0) + 4), 32'h1234_5678);
    for (int i = 0; i < 5; i++)
      chk("R4 payload A", rdm(bufa(0) + 12 + 32'(i) * 4), 32'hA000_0000 + 32'(i));
    rd_reg(2'd3, rd); chk("R3 cur advance", rd, 32'h2008);

    // R5 frame spanning two descriptors
    prev = irq_cnt;
    wr_reg(2'd2, 32'd24);
    send_frame(6, 32'hB000_0000);
    wait_irq(prev);
    chk("R6 header B", rdm(bufa(1) + 8), hdr(24, 2));
    chk("R5 payload B0", rdm(bufa(1) + 12), 32'hB000_0000);
    for (int i = 1; i < 6; i++)
      chk("R5 payload B", rdm(bufa(2) + 32'(i - 1) * 4), 32'hB000_0000 + 32'(i));
    rd_reg(2'd3, rd); chk("R8 status B", rd, 32'h2018);
    chk("R7 irq count", 32'(irq_cnt), 32'd2);

    // R9 overflow continue drops frame
    wr_reg(2'd0, 32'h411);
    prev = irq_cnt;
    send_frame(3, 32'hC000_0000);
    repeat (10) @(negedge clk);
    chk("R9 no irq", 32'(irq_cnt), 32'(prev));
    chk("R9 no write", {31'b0, mem.exists((bufa(3) + 8) >> 2)}, 32'd0);
    rd_reg(2'd3, rd); chk("R9 still waiting", rd, 32'h2018);

    // R3 end-of-table wrap
    set_desc(3, 64, 1, bufa(3));
    prev = irq_cnt;
    wr_reg(2'd2, 32'd0);
    send_frame(2, 32'hD000_0000);
    wait_irq(prev);
    chk("R6 header D", rdm(bufa(3) + 8), hdr(8, 1));
    chk("R4 payload D", rdm(bufa(3) + 16), 32'hD000_0001);
    rd_reg(2'd3, rd); chk("R3 wrap", rd, 32'h2000);

    // R12 descriptor smaller than offset+4
    wr_reg(2'd0, 32'h11);
    set_desc(0, 8, 0, bufa(0));
    wr_reg(2'd2, 32'd8);
    hold_valid(20);
    rd_reg(2'd3, rd); chk("R12 protocol error", rd, 32'h0001_3008);
    chk("R10 no ready halted", {31'b0, st_ready}, 32'd0);
    st_valid = 1'b0;

    // R13 disable clears error, re-enable restarts at 0
    wr_reg(2'd0, 32'h10);
    rd_reg(2'd3, rd); chk("R13 disabled", rd, 32'h0000_0008);
    set_desc(0, 64, 0, bufa(0));
    wr_reg(2'd0, 32'h11);
    rd_reg(2'd3, rd); chk("R13 restart", rd, 32'h1000);

    // R10 overflow halt
    prev = irq_cnt;
    send_frame(1, 32'hE000_0000);
    wait_irq(prev);
    chk("R6 header E", rdm(bufa(0) + 8), hdr(4, 1));
    hold_valid(20);
    rd_reg(2'd3, rd); chk("R10 overflow halt", rd, 32'h0002_3008);
    chk("R10 ready low", {31'b0, st_ready}, 32'd0);
    st_valid = 1'b0;
    wr_reg(2'd0, 32'h10);

    // R11 descriptor read error
    err_on = 1'b1; err_addr = BASE;
    wr_reg(2'd0, 32'h11);
    hold_valid(20);
    rd_reg(2'd3, rd); chk("R11 desc error", rd, 32'h0004_3000);
    st_valid = 1'b0;
    wr_reg(2'd0, 32'h10);

    // R11 buffer write error
    err_addr = bufa(0) + 12;
    wr_reg(2'd0, 32'h11);
    hold_valid(20);
    rd_reg(2'd3, rd); chk("R11 write error", rd, 32'h0003_3008);
    st_valid = 1'b0;
    wr_reg(2'd0, 32'h10);
    err_on = 1'b0;

    // random frames over a four-entry wrapping ring (R3 R4 R5 R6 R7 R8)
    for (int d = 0; d < 4; d++) set_desc(d, 64, d == 3, bufa(d));
    wr_reg(2'd2, 32'd24);
    wr_reg(2'd0, 32'h1);
    begin
      int cur = 0;
      for (int f = 0; f < 30; f++) begin
        int off, n, idx, room, nd, pidx, bad;
        logic [31:0] a, h, tagv;
        logic [31:0] ea [64];
        off  = int'($urandom % 5) * 4;
        n    = 1 + int'($urandom % 40);
        pidx = (cur + 3) % 4;
        tagv = {8'(f), 8'h5A, 16'h0};
        wr_reg(2'd0, 32'h1 | (32'(off | int'($urandom % 4)) << 1));
        wr_reg(2'd2, 32'(pidx) * 8);
        idx = cur; h = bufa(idx) + 32'(off); a = h + 4; room = 60 - off; nd = 1;
        idx = (idx + 1) % 4;
        for (int i = 0; i < n; i++) begin
          if (room == 0) begin
            a = bufa(idx); room = 64; idx = (idx + 1) % 4; nd++;
          end
          ea[i] = a; a += 4; room -= 4;
        end
        prev = irq_cnt;
        send_frame(n, tagv);
        wait_irq(prev);
        chk("R7 random irq", 32'(irq_cnt), 32'(prev + 1));
        chk("R6 random header", rdm(h), hdr(n * 4, nd));
        bad = 0;
        for (int i = 0; i < n; i++) if (rdm(ea[i]) !== tagv + 32'(i)) bad++;
        chk("R5 random payload mismatches", 32'(bad), 32'd0);
        cur = idx;
        rd_reg(2'd3, rd);
        chk("R8 random status", rd, (32'((cur == pidx) ? 2 : 1) << 12) | (32'(cur) * 8));
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule